// File: doc/BRIEF.md
# Buck Converter Startup and Protection Sequencer

This block is the digital supervisor of a single-phase step-down regulator. It watches a set of flags coming from analog comparators (supply good, enable, output too high, output too low, two current-limit levels and output discharged). From them it decides when the converter may switch, produces the code that a reference DAC turns into the soft-start ramp, and drives the enable lines of the high-side and low-side gate drivers, a power-good output and a discharge command.

After the supply is good and enable is released, it waits a fixed number of cycles and then ramps the reference code one step per switching cycle from zero to full scale. Three cycles after the ramp reaches full scale, power-good goes high. From then on every fault leads to a defined shutdown. Overvoltage latches with the low-side switch held on. Undervoltage after the ramp, and the high current limit, latch both switches off. The lower current limit starts a limited number of automatic restarts before it also latches. A shutdown commanded by enable, or caused by a fault, drives the discharge output until the output has bled down.

Top module: `buck_startup_seq`

## Requirements
- R1: Every input flag is synchronized by two flops. Startup begins only when supply-ok and enable are both high. `hs_en` rises exactly 3 + START_DLY clock edges after both inputs are high.
- R2: During the ramp, `ref_code` is 0 in the first cycle and rises by exactly one each cycle up to all ones (2^REF_W - 1). The ramp therefore takes 2^REF_W cycles. `ref_code` is 0 in every state outside the ramp and regulation.
- R3: `pgood` rises exactly PG_DLY (3) cycles after the ramp has spent its cycle at full scale. It is low in every other state.
- R4: A high overvoltage flag in any state, including while disabled, forces `hs_en`=0, `ls_en`=1 and `pgood`=0. This latch is released only when enable (or supply) is low and the flag is clear. On release both gate enables are 0.
- R5: During the ramp, the undervoltage flag has no effect while `ref_code` is below floor((2^REF_W-1)*4/5), which is 818 by default. At or above that code, the flag turns the gates off, returns `ref_code` to 0 and restarts the pre-start delay, followed by a complete new ramp.
- R6: An undervoltage flag after the ramp latches both gate enables off and drops `pgood`. Only a low enable or a low supply clears the latch.
- R7: The high current-limit flag, during the ramp or in regulation, immediately latches both gate enables off.
- R8: The low current-limit flag counts as an event only after it has been high for OC_MASK (4) consecutive cycles. Shorter pulses have no effect.
- R9: Each low current-limit event turns the gates off for RETRY_DLY cycles and then restarts the ramp from zero. At most OC_RETRY (4) such restarts are allowed. The next event latches both gates off.
- R10: The restart count returns to zero each time a ramp reaches full scale.
- R11: `discharge` is high, with both gates off, after a disable and after an undervoltage or current-limit latch, for as long as the output-discharged flag is low.
- R12: `ls_en` is low in the first cycle of every ramp and high for the rest of the ramp and during regulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | switching-rate clock |
| rst_n | input | 1 | active-low reset |
| supply_ok | input | 1 | both supply rails above lockout (async) |
| enable | input | 1 | enable released (async) |
| ov_flag | input | 1 | output above overvoltage limit (async) |
| uv_flag | input | 1 | output below undervoltage limit (async) |
| oc_lo_flag | input | 1 | current above lower limit (async) |
| oc_hi_flag | input | 1 | current above upper limit (async) |
| below_dis | input | 1 | output below discharge-done level (async) |
| ref_code | output | REF_W | soft-start reference code |
| hs_en | output | 1 | high-side driver enable |
| ls_en | output | 1 | low-side driver enable |
| pgood | output | 1 | power-good |
| discharge | output | 1 | output discharge command |

## Verification
The startup is first blocked by a missing supply and then released, so that the exact delay and the cycle-by-cycle ramp and power-good timing can be measured. Undervoltage pulses are applied below and above the arming code, which shows whether the ramp masks them or restarts. Low current-limit pulses of three and of four cycles show the masking boundary. A run of events split by a completed ramp shows whether the restart count is cleared or keeps counting toward the latch. Overvoltage is applied while regulating and while disabled, and the low-side clamp and its release condition are checked in both cases.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_DELAY,
    ST_RAMP,
    ST_PGWAIT,
    ST_RUN,
    ST_OCWAIT,
    ST_OVLATCH,
    ST_FLTOFF,
    ST_DISCH
  } bss_state_e;

  // flag positions in the synchronized bundle
  localparam int FL_SUP = 0;
  localparam int FL_EN  = 1;
  localparam int FL_OV  = 2;
  localparam int FL_UV  = 3;
  localparam int FL_OCL = 4;
  localparam int FL_OCH = 5;
  localparam int FL_BLW = 6;
  localparam int NFLAGS = 7;

  function automatic int ramp_top(input int w);
    return (1 << w) - 1;
  endfunction

  // undervoltage monitoring is armed at 80 % of full scale
  function automatic int uv_arm_code(input int w);
    return (ramp_top(w) * 4) / 5;
  endfunction

  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bss_ramp.sv
module bss_ramp
  import bss_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_zero,
  input  logic         step,
  output logic [W-1:0] code,
  output logic         at_top,
  output logic         uv_armed
);
  localparam logic [W-1:0] TOP = W'(ramp_top(W));
  localparam logic [W-1:0] ARM = W'(uv_arm_code(W));

  assign at_top   = (code == TOP);
  assign uv_armed = (code >= ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (hold_zero) begin
      code <= '0;
    end else if (step && !at_top) begin
      code <= code + 1'b1;
    end
  end
endmodule

// File: rtl/bss_oc_guard.sv
module bss_oc_guard #(
  parameter int MASK  = 4,
  parameter int RETRY = 4,
  localparam int MW   = (MASK > 1) ? $clog2(MASK) : 1,
  localparam int RCW  = $clog2(RETRY + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           watch,
  input  logic           oc_lo,
  input  logic           take,
  input  logic           clear,
  output logic           oc_evt,
  output logic           spent,
  output logic [RCW-1:0] used
);
  localparam logic [MW-1:0]  RUN_LAST = MW'(MASK - 1);
  localparam logic [RCW-1:0] USED_MAX = RCW'(RETRY);

  logic [MW-1:0] run;

  assign oc_evt = watch && oc_lo && (run == RUN_LAST);
  assign spent  = (used == USED_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (!watch || !oc_lo) begin
      run <= '0;
    end else if (run != RUN_LAST) begin
      run <= run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
    end else if (clear) begin
      used <= '0;
    end else if (take && !spent) begin
      used <= used + 1'b1;
    end
  end
endmodule

// File: rtl/buck_startup_seq.sv
module buck_startup_seq
  import bss_pkg::*;
#(
  parameter int REF_W     = 10,
  parameter int START_DLY = 64,
  parameter int RETRY_DLY = 64,
  parameter int PG_DLY    = 3,
  parameter int OC_MASK   = 4,
  parameter int OC_RETRY  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             enable,
  input  logic             ov_flag,
  input  logic             uv_flag,
  input  logic             oc_lo_flag,
  input  logic             oc_hi_flag,
  input  logic             below_dis,
  output logic [REF_W-1:0] ref_code,
  output logic             hs_en,
  output logic             ls_en,
  output logic             pgood,
  output logic             discharge
);
  localparam int DCW = cnt_width((START_DLY > RETRY_DLY) ? START_DLY : RETRY_DLY, PG_DLY);
  localparam int RCW = $clog2(OC_RETRY + 1);
  localparam logic [DCW-1:0] START_LAST = DCW'(START_DLY - 1);
  localparam logic [DCW-1:0] RETRY_LAST = DCW'(RETRY_DLY - 1);
  localparam logic [DCW-1:0] PG_LAST    = DCW'(PG_DLY - 1);

  // synchronized flags
  logic [NFLAGS-1:0] raw_flags, syn_flags;
  logic go_s, ov_s, uv_s, ocl_s, och_s, blw_s;

  assign raw_flags = {below_dis, oc_hi_flag, oc_lo_flag, uv_flag, ov_flag, enable, supply_ok};

  bss_sync #(.W(NFLAGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_flags),
    .q     (syn_flags)
  );

  assign go_s  = syn_flags[FL_SUP] && syn_flags[FL_EN];
  assign ov_s  = syn_flags[FL_OV];
  assign uv_s  = syn_flags[FL_UV];
  assign ocl_s = syn_flags[FL_OCL];
  assign och_s = syn_flags[FL_OCH];
  assign blw_s = syn_flags[FL_BLW];

  // state and delay counter
  bss_state_e     state, nxt;
  logic [DCW-1:0] dcnt;
  logic           ramp_on, active;
  logic           at_top, uv_armed;
  logic           oc_evt, retry_spent, take_retry, clr_retry;
  logic [RCW-1:0] retry_used;

  assign ramp_on = (state == ST_RAMP);
  assign active  = (state == ST_RAMP) || (state == ST_PGWAIT) || (state == ST_RUN);

  bss_ramp #(.W(REF_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (!active),
    .step      (ramp_on),
    .code      (ref_code),
    .at_top    (at_top),
    .uv_armed  (uv_armed)
  );

  bss_oc_guard #(.MASK(OC_MASK), .RETRY(OC_RETRY)) u_oc (
    .clk    (clk),
    .rst_n  (rst_n),
    .watch  (active),
    .oc_lo  (ocl_s),
    .take   (take_retry),
    .clear  (clr_retry),
    .oc_evt (oc_evt),
    .spent  (retry_spent),
    .used   (retry_used)
  );

  // current-limit decision shared by the active states
  function automatic bss_state_e oc_next(input logic hi, input logic evt,
                                         input logic spent_i, input bss_state_e stay);
    if (hi)            return ST_FLTOFF;
    else if (evt)      return spent_i ? ST_FLTOFF : ST_OCWAIT;
    else               return stay;
  endfunction

  always_comb begin
    nxt = state;
    if (ov_s && state != ST_OVLATCH) begin
      nxt = ST_OVLATCH;
    end else if (!go_s && state != ST_OFF && state != ST_DISCH && state != ST_OVLATCH) begin
      nxt = ST_DISCH;
    end else begin
      unique case (state)
        ST_OFF:     if (go_s) nxt = ST_DELAY;
        ST_DELAY:   if (dcnt == START_LAST) nxt = ST_RAMP;
        ST_RAMP: begin
          nxt = oc_next(och_s, oc_evt, retry_spent, ST_RAMP);
          if (nxt == ST_RAMP) begin
            if (uv_s && uv_armed) nxt = ST_DELAY;
            else if (at_top)      nxt = ST_PGWAIT;
          end
        end
        ST_PGWAIT: begin
          nxt = oc_next(och_s, oc_evt, retry_spent, ST_PGWAIT);
          if (nxt == ST_PGWAIT) begin
            if (uv_s)                  nxt = ST_FLTOFF;
            else if (dcnt == PG_LAST)  nxt = ST_RUN;
          end
        end
        ST_RUN: begin
          nxt = oc_next(och_s, oc_evt, retry_spent, ST_RUN);
          if (nxt == ST_RUN && uv_s) nxt = ST_FLTOFF;
        end
        ST_OCWAIT:  if (dcnt == RETRY_LAST) nxt = ST_RAMP;
        ST_OVLATCH: if (!go_s && !ov_s) nxt = ST_OFF;
        ST_FLTOFF:  nxt = ST_FLTOFF;
        ST_DISCH:   if (blw_s) nxt = ST_OFF;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  assign take_retry = (nxt == ST_OCWAIT) && (state != ST_OCWAIT);
  assign clr_retry  = (state == ST_RAMP) && (nxt == ST_PGWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      dcnt  <= '0;
    end else begin
      state <= nxt;
      dcnt  <= (nxt != state) ? '0 : dcnt + 1'b1;
    end
  end

  // outputs decoded from state
  assign hs_en     = active;
  assign ls_en     = (state == ST_OVLATCH) || (active && !(ramp_on && ref_code == '0));
  assign pgood     = (state == ST_RUN);
  assign discharge = (state == ST_DISCH) || (state == ST_FLTOFF && !blw_s);

endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int REF_W    = 10,
  parameter int OC_RETRY = 4,
  parameter int RCW      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REF_W-1:0] ref_code,
  input logic             hs_en,
  input logic             ls_en,
  input logic             pgood,
  input logic             discharge,
  input logic             go_s,
  input logic             ov_s,
  input logic             uv_s,
  input logic             och_s,
  input logic             oc_evt,
  input logic             ramp_on,
  input logic             active,
  input logic             uv_armed,
  input logic             at_top,
  input logic [RCW-1:0]   retry_used
);
  p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_on && $past(ramp_on)) |-> (ref_code == $past(ref_code) + 1'b1));

  p_pg_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (hs_en && ls_en && ref_code == '1));

  p_ov_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |=> (ls_en && !hs_en && !pgood));

  p_uv_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_on && uv_s && !uv_armed && go_s && !ov_s && !och_s && !oc_evt && !at_top) |=> ramp_on);

  p_hi_oc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && och_s) |=> !hs_en);

  p_retry_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_used <= RCW'(OC_RETRY));

  p_dis_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    discharge |-> (!hs_en && !ls_en));

  p_ls_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !ls_en);
endmodule

bind buck_startup_seq bss_checker #(
  .REF_W    (REF_W),
  .OC_RETRY (OC_RETRY),
  .RCW      (RCW)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_code   (ref_code),
  .hs_en      (hs_en),
  .ls_en      (ls_en),
  .pgood      (pgood),
  .discharge  (discharge),
  .go_s       (go_s),
  .ov_s       (ov_s),
  .uv_s       (uv_s),
  .och_s      (och_s),
  .oc_evt     (oc_evt),
  .ramp_on    (ramp_on),
  .active     (active),
  .uv_armed   (uv_armed),
  .at_top     (at_top),
  .retry_used (retry_used)
);

// File: tb/test_buck_startup_seq.sv
module test_buck_startup_seq;
  localparam int REF_W     = 10;
  localparam int START_DLY = 64;
  localparam int RETRY_DLY = 64;
  localparam int PG_DLY    = 3;
  localparam int LAT       = 3;            // two sync flops + state register
  localparam int TOPC      = (1 << REF_W) - 1;
  localparam int ARMC      = (TOPC * 4) / 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, enable = 1'b0, ov_flag = 1'b0, uv_flag = 1'b0;
  logic oc_lo_flag = 1'b0, oc_hi_flag = 1'b0, below_dis = 1'b0;
  logic [REF_W-1:0] ref_code;
  logic hs_en, ls_en, pgood, discharge;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  buck_startup_seq #(
    .REF_W(REF_W), .START_DLY(START_DLY), .RETRY_DLY(RETRY_DLY), .PG_DLY(PG_DLY)
  ) i_buck_startup_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .oc_lo_flag(oc_lo_flag),
    .oc_hi_flag(oc_hi_flag), .below_dis(below_dis), .ref_code(ref_code),
    .hs_en(hs_en), .ls_en(ls_en), .pgood(pgood), .discharge(discharge)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_hs(output int n, input int lim);
    n = 0;
    while (!hs_en && n < lim) begin tick(1); n++; end
  endtask

  task automatic wait_pg(output int n, input int lim);
    n = 0;
    while (!pgood && n < lim) begin tick(1); n++; end
  endtask

  task automatic restart_to_ramp();
    int n;
    enable = 1'b0; below_dis = 1'b1;
    tick(10);
    below_dis = 1'b0; enable = 1'b1; supply_ok = 1'b1;
    wait_hs(n, 500);
  endtask

  task automatic run_up();
    int n;
    restart_to_ramp();
    wait_pg(n, 3000);
  endtask

  task automatic oc_pulse(input int len);
    oc_lo_flag = 1'b1;
    tick(len);
    oc_lo_flag = 1'b0;
  endtask

  task automatic t_reset();
    tick(5);
    chk("R3", "pgood in reset", int'(pgood), 0);
    chk("R1", "hs_en in reset", int'(hs_en), 0);
    rst_n = 1'b1;
    tick(3);
    chk("R2", "ref after reset", int'(ref_code), 0);
    chk("R11", "discharge after reset", int'(discharge), 0);
  endtask

  task automatic t_no_supply();
    enable = 1'b1; supply_ok = 1'b0;
    tick(150);
    chk("R1", "hs_en without supply", int'(hs_en), 0);
  endtask

  task automatic t_startup();
    int n, bad, exp;
    supply_ok = 1'b1;
    wait_hs(n, 500);
    chk("R1", "start delay", n, LAT + START_DLY);
    chk("R12", "ls_en first ramp cycle", int'(ls_en), 0);
    bad = 0; n = 0;
    while (!pgood && n < 3000) begin
      exp = (n < TOPC) ? n : TOPC;
      if (int'(ref_code) != exp) bad++;
      tick(1); n++;
      if (n == 1) chk("R12", "ls_en second ramp cycle", int'(ls_en), 1);
    end
    chk("R2", "ramp step mismatches", bad, 0);
    chk("R3", "pgood delay after ramp start", n, TOPC + 1 + PG_DLY);
  endtask

  task automatic t_uv_ramp();
    int n;
    restart_to_ramp();
    tick(100);
    uv_flag = 1'b1; tick(40); uv_flag = 1'b0;
    chk("R5", "hs_en with early uv", int'(hs_en), 1);
    chk("R5", "ref unaffected by early uv", int'(ref_code), 140);
    while (int'(ref_code) < ARMC + 30) tick(1);
    uv_flag = 1'b1; tick(4);
    chk("R5", "hs_en after armed uv", int'(hs_en), 0);
    chk("R5", "ref after armed uv", int'(ref_code), 0);
    uv_flag = 1'b0;
    wait_hs(n, 500);
    chk("R5", "restart delay", n, START_DLY - 1);
    wait_pg(n, 3000);
    chk("R5", "restarted ramp completes", int'(pgood), 1);
  endtask

  task automatic t_uv_run();
    int n;
    run_up();
    uv_flag = 1'b1; tick(4);
    chk("R6", "hs_en after uv in run", int'(hs_en), 0);
    chk("R6", "ls_en after uv in run", int'(ls_en), 0);
    chk("R6", "pgood after uv in run", int'(pgood), 0);
    chk("R11", "discharge after uv latch", int'(discharge), 1);
    uv_flag = 1'b0; tick(100);
    chk("R6", "uv latch holds", int'(hs_en), 0);
    below_dis = 1'b1; tick(4);
    chk("R11", "discharge ends at threshold", int'(discharge), 0);
    below_dis = 1'b0; enable = 1'b0; tick(4);
    chk("R11", "discharge on disable", int'(discharge), 1);
    below_dis = 1'b1; tick(4);
    chk("R11", "discharge off when discharged", int'(discharge), 0);
    enable = 1'b1;
    wait_hs(n, 500);
    chk("R6", "restart after enable cycle", n, LAT + START_DLY);
    below_dis = 1'b0;
  endtask

  task automatic t_ov();
    run_up();
    ov_flag = 1'b1; tick(4);
    chk("R4", "hs_en under ov", int'(hs_en), 0);
    chk("R4", "ls_en under ov", int'(ls_en), 1);
    chk("R4", "pgood under ov", int'(pgood), 0);
    ov_flag = 1'b0; tick(50);
    chk("R4", "ov latch holds low side", int'(ls_en), 1);
    enable = 1'b0; tick(5);
    chk("R4", "ov latch released", int'(ls_en), 0);
    ov_flag = 1'b1; tick(4);
    chk("R4", "ov while disabled", int'(ls_en), 1);
    ov_flag = 1'b0; tick(4);
    chk("R4", "ov while disabled released", int'(ls_en), 0);
  endtask

  task automatic t_oc_hi();
    restart_to_ramp();
    tick(20);
    oc_hi_flag = 1'b1; tick(1); oc_hi_flag = 1'b0; tick(3);
    chk("R7", "hs_en after high limit", int'(hs_en), 0);
    chk("R7", "ls_en after high limit", int'(ls_en), 0);
    tick(100);
    chk("R7", "high limit latched", int'(hs_en), 0);
  endtask

  task automatic t_oc_lo_mask();
    int n;
    restart_to_ramp();
    tick(10);
    oc_pulse(3); tick(10);
    chk("R8", "3-cycle pulse ignored", int'(hs_en), 1);
    oc_pulse(4); tick(3);
    chk("R8", "4-cycle pulse acts", int'(hs_en), 0);
    wait_hs(n, 500);
    chk("R9", "retry off time", n, RETRY_DLY - 1);
    wait_pg(n, 3000);
    chk("R10", "ramp completes after retry", int'(pgood), 1);
  endtask

  task automatic t_retry();
    int n;
    for (int k = 1; k <= 4; k++) begin
      if (k > 1) tick(10);
      oc_pulse(4); tick(3);
      chk("R9", $sformatf("gates off at event %0d", k), int'(hs_en), 0);
      wait_hs(n, 500);
      // event 4 is the fifth since the first: only a cleared count allows it
      chk(k == 4 ? "R10" : "R9", $sformatf("restart at event %0d", k), int'(hs_en), 1);
    end
    tick(10);
    oc_pulse(4); tick(3);
    tick(200);
    chk("R9", "latched after retries spent", int'(hs_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_supply();
    t_startup();
    t_uv_ramp();
    t_uv_run();
    t_ov();
    t_oc_hi();
    t_oc_lo_mask();
    t_retry();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule